// File: doc/BRIEF.md
# Multi-CPU Pending Interrupt Arbiter

This block chooses, for every CPU of a cluster, which interrupt that CPU should be told about. Each interrupt has an enable bit and a pending bit per CPU, plus an 8-bit priority. For the low bank of 32 interrupts the priority is held separately for each CPU. For higher-numbered interrupts one priority value is shared by all CPUs. Among the interrupts that are both enabled and pending for a CPU, the smallest priority value wins. When two candidates have the same priority, the smaller interrupt number wins.

The winner is then filtered twice. It is published as the CPU's highest-pending ID only if its priority does not exceed that CPU's priority mask; otherwise the published ID is the spurious code 1023. The CPU's request line goes high only when the published winner's priority is strictly below the CPU's running priority. The running priority is 9 bits wide, and 0x100 means the CPU is idle. A cleared distributor enable or a cleared CPU interface enable forces that CPU's outputs to the spurious, quiet state. Both outputs are registered, so they follow the inputs with one cycle of latency.

All pins are level-sensitive control and status. No data is transferred, so there is no valid/ready handshake and no back-pressure: the outputs are continuously re-evaluated and simply hold their last value. Flat vectors are indexed interrupt-major: bit `irq*NUM_CPU + cpu` of the enable and pending inputs belongs to interrupt `irq` as seen by CPU `cpu`.

Top module: `pia_arbiter`

## Requirements
- R1: When `dist_en_i` is 0, or the CPU's bit of `cpu_en_i` is 0, that CPU's `irq_req_o` bit is 0 and its `hp_id_o` field is 1023 one cycle later.
- R2: An interrupt is a candidate for CPU c only if both bit `irq*NUM_CPU+c` of `irq_en_i` and the same bit of `irq_pend_i` are 1. Bits belonging to other CPUs have no effect on CPU c.
- R3: Among the candidates, the one with the smallest priority value is chosen; when priorities are equal, the smaller interrupt number is chosen.
- R4: The chosen ID is published in `hp_id_o` (10-bit field `c*10 +: 10`) only when its priority is less than or equal to the CPU's mask (`prio_mask_i[c*8 +: 8]`); otherwise the field reads 1023.
- R5: `irq_req_o[c]` is 1 only when an ID is published and its priority is strictly less than the running priority `run_prio_i[c*9 +: 9]`. An equal running priority keeps the line low.
- R6: Interrupt i below 32 takes its priority from `bank_prio_i[(i*NUM_CPU+c)*8 +: 8]`, which may differ per CPU. Interrupt i of 32 or above takes its priority from `shared_prio_i[(i-32)*8 +: 8]` for every CPU.
- R7: A running priority of 0x100 (idle) lets any published candidate raise the request, including priority 0xFF under mask 0xFF.
- R8: The outputs are registered. During reset they read ID 1023 with the request low, and after reset each change on the inputs appears on the outputs at the next rising clock edge and not before.
- R9: With no candidate for a CPU, its ID reads 1023 and its request is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dist_en_i | input | 1 | Global distributor enable |
| cpu_en_i | input | NUM_CPU | Per-CPU interface enable |
| irq_en_i | input | NUM_IRQ*NUM_CPU | Enable bits, interrupt-major |
| irq_pend_i | input | NUM_IRQ*NUM_CPU | Pending bits, interrupt-major |
| bank_prio_i | input | 32*NUM_CPU*8 | Per-CPU priorities of interrupts 0..31 |
| shared_prio_i | input | (NUM_IRQ-32)*8 | Shared priorities of interrupts 32 and above |
| prio_mask_i | input | NUM_CPU*8 | Per-CPU priority mask |
| run_prio_i | input | NUM_CPU*9 | Per-CPU running priority (0x100 = idle) |
| hp_id_o | output | NUM_CPU*10 | Per-CPU highest-pending ID (1023 = none) |
| irq_req_o | output | NUM_CPU | Per-CPU interrupt request |

## Verification
Every cycle, the assertions check three things. First, the tree's winner is no worse than any valid leaf and wins ties by the lower number. Second, a disabled CPU, a CPU with no candidate, or a masked winner always produces the spurious, quiet outputs one cycle later. Third, a raised request always comes with a real ID, and an idle CPU with a published winner always gets its request. The bench scenarios cover the rest. They show that the correct interrupt is picked when CPUs hold different banked priorities, and that the bits of other CPUs are ignored. They also cover the exact mask and running-priority boundaries, and the one-cycle output latency.

// File: rtl/pia_pkg.sv
package pia_pkg;
  localparam int PRIO_W      = 8;
  localparam int RUN_W       = PRIO_W + 1;
  localparam int ID_W        = 10;
  localparam int BANKED_IRQS = 32;
  localparam logic [ID_W-1:0]  SPURIOUS_ID = 10'd1023;
  localparam logic [RUN_W-1:0] IDLE_RUN    = 9'h100;

  typedef struct packed {
    logic              vld;
    logic [PRIO_W-1:0] prio;
    logic [ID_W-1:0]   id;
  } cand_t;

  // Left operand carries the lower interrupt numbers, so it keeps ties.
  function automatic cand_t pick(input cand_t a, input cand_t b);
    if (a.vld && (!b.vld || a.prio <= b.prio)) return a;
    return b;
  endfunction
endpackage

// File: rtl/pia_leaf_gather.sv
module pia_leaf_gather
  import pia_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic [NUM_IRQ-1:0]                 en_i,
  input  logic [NUM_IRQ-1:0]                 pend_i,
  input  logic [BANKED_IRQS*PRIO_W-1:0]      bank_prio_i,
  input  logic [(NUM_IRQ-BANKED_IRQS)*PRIO_W-1:0] shared_prio_i,
  output cand_t [NUM_IRQ-1:0]                leaf_o
);
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_leaf
    logic [PRIO_W-1:0] prio;
    if (i < BANKED_IRQS) begin : g_banked
      assign prio = bank_prio_i[i*PRIO_W +: PRIO_W];
    end else begin : g_shared
      assign prio = shared_prio_i[(i-BANKED_IRQS)*PRIO_W +: PRIO_W];
    end
    assign leaf_o[i].vld  = en_i[i] & pend_i[i];
    assign leaf_o[i].prio = prio;
    assign leaf_o[i].id   = ID_W'(i);
  end
endmodule

// File: rtl/pia_min_tree.sv
module pia_min_tree
  import pia_pkg::*;
#(
  parameter int N = 64
) (
  input  cand_t [N-1:0] leaf_i,
  output cand_t         best_o
);
  localparam int LEVELS = (N > 1) ? $clog2(N) : 0;
  localparam int LEAVES = 1 << LEVELS;

  always_comb begin
    cand_t work [LEAVES];
    for (int j = 0; j < LEAVES; j++) begin
      work[j] = (j < N) ? leaf_i[j] : '0;
    end
    for (int lv = 0; lv < LEVELS; lv++) begin
      for (int j = 0; j < (LEAVES >> (lv + 1)); j++) begin
        work[j] = pick(work[2*j], work[2*j+1]);
      end
    end
    best_o = work[0];
  end

  // R3: the winner beats or ties every candidate and wins ties by number.
  always_comb begin
    for (int j = 0; j < N; j++) begin
      if (leaf_i[j].vld) begin
        assert_min_tree_R3: assert (best_o.vld && best_o.prio <= leaf_i[j].prio &&
                                    (best_o.prio != leaf_i[j].prio || best_o.id <= leaf_i[j].id))
          else $error("tree winner worse than leaf %0d", j);
      end
    end
  end
endmodule

// File: rtl/pia_cpu_gate.sv
module pia_cpu_gate
  import pia_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  cand_t            best_i,
  input  logic [PRIO_W-1:0] mask_i,
  input  logic [RUN_W-1:0] run_i,
  output logic [ID_W-1:0]  id_o,
  output logic             req_o
);
  logic            show;
  logic [ID_W-1:0] id_d;
  logic            req_d;

  always_comb begin
    show  = en_i && best_i.vld && (best_i.prio <= mask_i);
    id_d  = show ? best_i.id : SPURIOUS_ID;
    req_d = show && ({1'b0, best_i.prio} < run_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_o  <= SPURIOUS_ID;
      req_o <= 1'b0;
    end else begin
      id_o  <= id_d;
      req_o <= req_d;
    end
  end

  assert_disabled_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!req_o && id_o == SPURIOUS_ID));
  assert_masked_spurious_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (best_i.vld && best_i.prio > mask_i) |=> (id_o == SPURIOUS_ID && !req_o));
  assert_req_has_id_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> id_o != SPURIOUS_ID);
  assert_idle_preempt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && best_i.vld && best_i.prio <= mask_i && run_i == IDLE_RUN) |=> req_o);
  assert_no_cand_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !best_i.vld |=> (id_o == SPURIOUS_ID && !req_o));
endmodule

// File: rtl/pia_arbiter.sv
module pia_arbiter
  import pia_pkg::*;
#(
  parameter int NUM_IRQ = 64,   // must exceed 32
  parameter int NUM_CPU = 4
) (
  input  logic                                    clk_i,
  input  logic                                    rst_ni,
  input  logic                                    dist_en_i,
  input  logic [NUM_CPU-1:0]                      cpu_en_i,
  input  logic [NUM_IRQ*NUM_CPU-1:0]              irq_en_i,
  input  logic [NUM_IRQ*NUM_CPU-1:0]              irq_pend_i,
  input  logic [BANKED_IRQS*NUM_CPU*PRIO_W-1:0]   bank_prio_i,
  input  logic [(NUM_IRQ-BANKED_IRQS)*PRIO_W-1:0] shared_prio_i,
  input  logic [NUM_CPU*PRIO_W-1:0]               prio_mask_i,
  input  logic [NUM_CPU*RUN_W-1:0]                run_prio_i,
  output logic [NUM_CPU*ID_W-1:0]                 hp_id_o,
  output logic [NUM_CPU-1:0]                      irq_req_o
);
  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_IRQ-1:0]            en_c;
    logic [NUM_IRQ-1:0]            pend_c;
    logic [BANKED_IRQS*PRIO_W-1:0] bprio_c;
    cand_t [NUM_IRQ-1:0]           leaf;
    cand_t                         best;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_slice
      assign en_c[i]   = irq_en_i[i*NUM_CPU + c];
      assign pend_c[i] = irq_pend_i[i*NUM_CPU + c];
    end
    for (genvar i = 0; i < BANKED_IRQS; i++) begin : g_bprio
      assign bprio_c[i*PRIO_W +: PRIO_W] = bank_prio_i[(i*NUM_CPU + c)*PRIO_W +: PRIO_W];
    end

    pia_leaf_gather #(.NUM_IRQ(NUM_IRQ)) u_gather (
      .en_i          (en_c),
      .pend_i        (pend_c),
      .bank_prio_i   (bprio_c),
      .shared_prio_i (shared_prio_i),
      .leaf_o        (leaf)
    );

    pia_min_tree #(.N(NUM_IRQ)) u_tree (
      .leaf_i (leaf),
      .best_o (best)
    );

    pia_cpu_gate u_gate (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (dist_en_i & cpu_en_i[c]),
      .best_i (best),
      .mask_i (prio_mask_i[c*PRIO_W +: PRIO_W]),
      .run_i  (run_prio_i[c*RUN_W +: RUN_W]),
      .id_o   (hp_id_o[c*ID_W +: ID_W]),
      .req_o  (irq_req_o[c])
    );
  end
endmodule

// File: tb/pia_arbiter_bench.sv
module pia_arbiter_bench;
  localparam int NI = 64;
  localparam int NC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dist_en = 1'b0;
  logic [NC-1:0] cpu_en = '0;
  logic [NI*NC-1:0] en_v = '0;
  logic [NI*NC-1:0] pend_v = '0;
  logic [32*NC*8-1:0] bprio = '0;
  logic [(NI-32)*8-1:0] sprio = '0;
  logic [NC*8-1:0] mask = '0;
  logic [NC*9-1:0] run = '0;
  logic [NC*10-1:0] hp_id;
  logic [NC-1:0] req;

  int vectors = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pia_arbiter #(.NUM_IRQ(NI), .NUM_CPU(NC)) u_pia_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .dist_en_i(dist_en), .cpu_en_i(cpu_en),
    .irq_en_i(en_v), .irq_pend_i(pend_v), .bank_prio_i(bprio),
    .shared_prio_i(sprio), .prio_mask_i(mask), .run_prio_i(run),
    .hp_id_o(hp_id), .irq_req_o(req));

  function automatic int prio_of(input int i, input int c);
    if (i < 32) return int'(bprio[(i*NC+c)*8 +: 8]);
    return int'(sprio[(i-32)*8 +: 8]);
  endfunction

  function automatic void model(input int c, output int id, output bit rq);
    int best = 1000;
    int idx = -1;
    id = 1023; rq = 1'b0;
    if (!dist_en || !cpu_en[c]) return;
    for (int i = 0; i < NI; i++) begin
      if (en_v[i*NC+c] && pend_v[i*NC+c] && prio_of(i, c) < best) begin
        best = prio_of(i, c); idx = i;
      end
    end
    if (idx >= 0 && best <= int'(mask[c*8 +: 8])) begin
      id = idx;
      rq = (best < int'(run[c*9 +: 9]));
    end
  endfunction

  task automatic cmp(input string tag, input int c, input int exp_id, input bit exp_rq);
    int got_id = int'(hp_id[c*10 +: 10]);
    vectors++;
    if (got_id != exp_id || req[c] != exp_rq) begin
      errors++;
      $display("FAIL %s cpu%0d: id %0d req %0d, expected id %0d req %0d",
               tag, c, got_id, req[c], exp_id, exp_rq);
    end
  endtask

  // Inputs were changed at a negedge; registers load at the next posedge.
  task automatic step_check(input string tag);
    @(posedge clk); @(negedge clk);
    for (int c = 0; c < NC; c++) begin
      int e; bit r;
      model(c, e, r);
      cmp(tag, c, e, r);
    end
  endtask

  task automatic clear_all();
    en_v = '0; pend_v = '0; bprio = '0; sprio = '0;
    dist_en = 1'b1; cpu_en = '1;
    for (int c = 0; c < NC; c++) begin
      mask[c*8 +: 8] = 8'hFF;
      run[c*9 +: 9] = 9'h100;
    end
  endtask

  task automatic arm(input int i, input int c);
    en_v[i*NC+c] = 1'b1; pend_v[i*NC+c] = 1'b1;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1C0FFEE));
    clear_all();
    en_v = '1; pend_v = '1;
    repeat (3) @(negedge clk);
    for (int c = 0; c < NC; c++) cmp("R8 reset", c, 1023, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    clear_all();
    step_check("R9 no candidate");

    // R2: enabled+pending only for cpu0; irq 41 pending but not enabled on cpu1
    sprio[(40-32)*8 +: 8] = 8'h80; arm(40, 0);
    pend_v[41*NC+1] = 1'b1; en_v[41*NC+2] = 1'b1;
    step_check("R2 candidate filter");
    cmp("R2 cpu0 sees 40", 0, 40, 1'b1);
    cmp("R2 cpu1 ignores half-set", 1, 1023, 1'b0);

    // R3: ties and strictly lower value
    clear_all();
    sprio[(45-32)*8 +: 8] = 8'h20; sprio[(50-32)*8 +: 8] = 8'h20;
    arm(45, 1); arm(50, 1);
    step_check("R3 tie");
    cmp("R3 tie lower id", 1, 45, 1'b1);
    sprio[(60-32)*8 +: 8] = 8'h10; arm(60, 1);
    step_check("R3 lower value");
    cmp("R3 lower value wins", 1, 60, 1'b1);

    // R6: banked priority of irq 5 differs per CPU
    clear_all();
    for (int c = 0; c < NC; c++) begin arm(5, c); arm(33, c); end
    bprio[(5*NC+0)*8 +: 8] = 8'h30; bprio[(5*NC+1)*8 +: 8] = 8'h90;
    bprio[(5*NC+2)*8 +: 8] = 8'h50; bprio[(5*NC+3)*8 +: 8] = 8'h4F;
    sprio[(33-32)*8 +: 8] = 8'h50;
    step_check("R6 banked");
    cmp("R6 cpu0 banked", 0, 5, 1'b1);
    cmp("R6 cpu1 shared", 1, 33, 1'b1);
    cmp("R6 cpu2 tie banked", 2, 5, 1'b1);

    // R4: mask boundary
    clear_all();
    sprio[(34-32)*8 +: 8] = 8'h40; arm(34, 2);
    mask[2*8 +: 8] = 8'h40;
    step_check("R4 mask equal");
    cmp("R4 mask equal publishes", 2, 34, 1'b1);
    mask[2*8 +: 8] = 8'h3F;
    step_check("R4 mask below");
    cmp("R4 masked spurious", 2, 1023, 1'b0);

    // R5: running priority boundary
    clear_all();
    sprio[(35-32)*8 +: 8] = 8'h40; arm(35, 3);
    run[3*9 +: 9] = 9'h040;
    step_check("R5 run equal");
    cmp("R5 equal run no req", 3, 35, 1'b0);
    run[3*9 +: 9] = 9'h041;
    step_check("R5 run above");
    cmp("R5 lower than run req", 3, 35, 1'b1);

    // R7: idle preempted by 0xFF under mask 0xFF
    clear_all();
    sprio[(63-32)*8 +: 8] = 8'hFF; arm(63, 0);
    step_check("R7 idle");
    cmp("R7 idle 0xFF", 0, 63, 1'b1);

    // R8: outputs hold until the next edge
    clear_all(); arm(36, 1);
    step_check("R8 setup");
    dist_en = 1'b1; arm(2, 1);
    #1;
    cmp("R8 holds before edge", 1, 36, 1'b1);
    step_check("R8 after edge");

    // R1: global and per-CPU disable
    for (int c = 0; c < NC; c++) arm(7, c);
    dist_en = 1'b0;
    step_check("R1 dist off");
    cmp("R1 dist off cpu0", 0, 1023, 1'b0);
    dist_en = 1'b1; cpu_en[1] = 1'b0;
    step_check("R1 cpu off");
    cmp("R1 cpu1 off", 1, 1023, 1'b0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      for (int b = 0; b < NI*NC; b++) begin
        en_v[b] = ($urandom % 4) != 0;
        pend_v[b] = ($urandom % 8) == 0;
      end
      for (int b = 0; b < 32*NC; b++) bprio[b*8 +: 8] = 8'(($urandom % 8) * 32 + ($urandom % 2));
      for (int b = 0; b < NI-32; b++) sprio[b*8 +: 8] = 8'(($urandom % 8) * 32 + ($urandom % 2));
      for (int c = 0; c < NC; c++) begin
        mask[c*8 +: 8] = (($urandom % 2) != 0) ? 8'hFF : 8'($urandom);
        run[c*9 +: 9] = (($urandom % 3) == 0) ? 9'h100 : 9'($urandom % 257);
        cpu_en[c] = ($urandom % 10) != 0;
      end
      dist_en = ($urandom % 10) != 0;
      step_check("R2 R3 R4 R5 R6 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule